// File: doc/BRIEF.md
# Prescaled Modulo Timer

This block is a 16-bit up-counting timer that is controlled through a small 32-bit register port. Software picks a counting source (none, every system clock, or an external fixed-rate tick pulse) and a power-of-two prescale. Each prescaled tick advances the counter by one. When the counter equals the programmed modulus, the next tick reloads the programmed start value instead of incrementing. That reload transition sets a sticky overflow flag, which drives an interrupt line whenever the interrupt enable is set.

A two-state prescaler machine gates counting. Its states are HALTED and RUNNING. Transition *start* moves HALTED to RUNNING when the source select holds 1 or 2. Transition *stop* moves RUNNING to HALTED when the select holds 0 or 3. Transitions *idle* (HALTED to HALTED) and *run* (RUNNING to RUNNING) hold the current state. In HALTED the prescale divider is held at zero, so a restart always begins a full prescale period. Writing the counter register with any data reloads the start value, which lets software restart a period.

Top module: `tick_modulo_timer`

## Requirements
- R1: After reset the control, counter and start-value registers read 0, the modulus register reads 0x0000FFFF, and `irq` is low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (counter), 0x08 (modulus) and 0x4C (start value). In control, bits [2:0] are the prescale exponent, [4:3] the source select, bit 6 the interrupt enable and bit 7 the overflow flag. All other control bits, bits [31:16] of the other three registers, and any other offset read 0.
- R3: A source select of 0 or 3 freezes the counter. A select of 1 counts on every clock. A select of 2 counts only on cycles where `fixed_tick` is high.
- R4: With prescale exponent P, the counter advances once per 2^P enabled source cycles.
- R5: On a tick the counter increments, or it loads the start value when it equals the modulus. With a start value of 0 this gives one period per modulus+1 ticks. The counter wraps 0xFFFF to 0 if it lies above the modulus.
- R6: The overflow flag is set only on a tick that moves the counter from the modulus to the start value.
- R7: A write of any data to the counter register loads the start value on the next edge. This takes priority over a tick in the same cycle, and that tick then sets no flag.
- R8: A control write with bit 7 = 0 clears the flag, and bit 7 = 1 leaves it as it is. A reload in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly while the flag and the interrupt enable are both 1.
- R10: A source select of 0 or 3 resets the prescale divider. After a start, the first count needs a full 2^P enabled cycles, and enabled cycles start counting one clock after the enabling write.
- R11: New modulus and start values apply from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| fixed_tick | input | 1 | Fixed-frequency tick pulse, one clock wide per tick |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the reload, which sets the flag, and a control write that clears the flag. The second pair is a counter-register write and a tick that would otherwise wrap. The bench provokes both on purpose: it asks its reference model whether a wrap is due in the coming cycle and issues the clearing write or the counter write exactly then. It judges the result from the flag and `irq` values read back afterwards, which must show the flag still set in the first case and no flag in the second. A long random phase mixes writes of all four registers with random `fixed_tick` activity, so these collisions also occur without being aimed at.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // counting source selected by control bits [4:3]
    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_FIXED = 2'd2,
        SRC_RSVD  = 2'd3
    } clk_src_e;

    // prescaler gating state
    typedef enum logic {
        PS_HALTED  = 1'b0,
        PS_RUNNING = 1'b1
    } ps_state_e;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h04;
    localparam logic [7:0] OFS_MODULO = 8'h08;
    localparam logic [7:0] OFS_START  = 8'h4C;

    // control field positions
    localparam int CTRL_PS_LSB   = 0;
    localparam int CTRL_SRC_LSB  = 3;
    localparam int CTRL_IE_BIT   = 6;
    localparam int CTRL_FLAG_BIT = 7;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  clk_src_e        src_sel,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            fixed_tick,
    output logic            tick
);

    localparam int DIV_W = (1 << PS_W) - 1;

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] div_q, div_d, div_lim;
    logic             src_ok, src_en;

    // source decode
    always_comb begin
        src_ok = 1'b0;
        src_en = 1'b0;
        unique case (src_sel)
            SRC_SYS: begin
                src_ok = 1'b1;
                src_en = 1'b1;
            end
            SRC_FIXED: begin
                src_ok = 1'b1;
                src_en = fixed_tick;
            end
            default: begin
                src_ok = 1'b0;
                src_en = 1'b0;
            end
        endcase
    end

    // 2^P - 1, modular so that the largest exponent yields all ones
    assign div_lim = ({{(DIV_W-1){1'b0}}, 1'b1} << ps_sel) - {{(DIV_W-1){1'b0}}, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_HALTED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HALTED:  state_d = src_ok ? PS_RUNNING : PS_HALTED;
            PS_RUNNING: state_d = src_ok ? PS_RUNNING : PS_HALTED;
            default:    state_d = PS_HALTED;
        endcase
    end

    // outputs and divider next value
    always_comb begin
        tick  = 1'b0;
        div_d = div_q;
        unique case (state_q)
            PS_HALTED: begin
                div_d = '0;
            end
            PS_RUNNING: begin
                if (!src_ok) begin
                    div_d = '0;
                end else if (src_en) begin
                    if (div_q >= div_lim) begin
                        tick  = 1'b1;
                        div_d = '0;
                    end else begin
                        div_d = div_q + {{(DIV_W-1){1'b0}}, 1'b1};
                    end
                end
            end
            default: div_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] mod_val,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_pulse
);

    logic at_mod;

    assign at_mod    = (cnt_q == mod_val);
    assign ovf_pulse = tick && at_mod && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= init_val;
        end else if (tick) begin
            cnt_q <= at_mod ? init_val : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ovf_pulse,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [PS_W-1:0]   ps_sel,
    output clk_src_e          src_sel,
    output logic              irq_en,
    output logic              flag_q,
    output logic [CNT_W-1:0]  mod_q,
    output logic [CNT_W-1:0]  init_q,
    output logic              cnt_load
);

    localparam logic [CNT_W-1:0] MOD_RESET = '1;

    logic sel_ctrl, sel_count, sel_mod, sel_start;
    logic unused_wdata;

    assign sel_ctrl  = (reg_addr == ADDR_W'(OFS_CTRL));
    assign sel_count = (reg_addr == ADDR_W'(OFS_COUNT));
    assign sel_mod   = (reg_addr == ADDR_W'(OFS_MODULO));
    assign sel_start = (reg_addr == ADDR_W'(OFS_START));

    assign cnt_load     = reg_wr && sel_count;
    assign unused_wdata = ^{reg_wdata[DATA_W-1:CNT_W], reg_wdata[5]};

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_sel  <= '0;
            src_sel <= SRC_OFF;
            irq_en  <= 1'b0;
        end else if (reg_wr && sel_ctrl) begin
            ps_sel  <= reg_wdata[CTRL_PS_LSB +: PS_W];
            src_sel <= clk_src_e'(reg_wdata[CTRL_SRC_LSB +: 2]);
            irq_en  <= reg_wdata[CTRL_IE_BIT];
        end
    end

    // sticky overflow flag: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf_pulse) begin
            flag_q <= 1'b1;
        end else if (reg_wr && sel_ctrl && !reg_wdata[CTRL_FLAG_BIT]) begin
            flag_q <= 1'b0;
        end
    end

    // modulus and start value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q  <= MOD_RESET;
            init_q <= '0;
        end else if (reg_wr) begin
            if (sel_mod)   mod_q  <= reg_wdata[CNT_W-1:0];
            if (sel_start) init_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[CTRL_PS_LSB +: PS_W] = ps_sel;
            reg_rdata[CTRL_SRC_LSB +: 2]   = src_sel;
            reg_rdata[CTRL_IE_BIT]         = irq_en;
            reg_rdata[CTRL_FLAG_BIT]       = flag_q;
        end else if (sel_count) begin
            reg_rdata = DATA_W'(cnt_val);
        end else if (sel_mod) begin
            reg_rdata = DATA_W'(mod_q);
        end else if (sel_start) begin
            reg_rdata = DATA_W'(init_q);
        end
    end

endmodule

// File: rtl/tick_modulo_timer.sv
module tick_modulo_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fixed_tick,
    output logic              irq
);

    logic [PS_W-1:0]  ps_sel;
    clk_src_e         src_sel;
    logic             irq_en;
    logic             flag_q;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_load;
    logic             presc_tick;
    logic             ovf_pulse;

    tmr_regfile #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ovf_pulse(ovf_pulse),
        .cnt_val  (cnt_q),
        .ps_sel   (ps_sel),
        .src_sel  (src_sel),
        .irq_en   (irq_en),
        .flag_q   (flag_q),
        .mod_q    (mod_q),
        .init_q   (init_q),
        .cnt_load (cnt_load)
    );

    tmr_prescaler #(
        .PS_W(PS_W)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .ps_sel    (ps_sel),
        .fixed_tick(fixed_tick),
        .tick      (presc_tick)
    );

    tmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (presc_tick),
        .load     (cnt_load),
        .mod_val  (mod_q),
        .init_val (init_q),
        .cnt_q    (cnt_q),
        .ovf_pulse(ovf_pulse)
    );

    assign irq = flag_q & irq_en;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              flag_q,
    input logic              ovf_pulse,
    input logic              tick,
    input logic              load,
    input logic [1:0]        src,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  mod_q,
    input logic [CNT_W-1:0]  init_q
);

    logic ctrl_clear;
    assign ctrl_clear = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL)) && !reg_wdata[CTRL_FLAG_BIT];

    // R6
    ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> flag_q);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_clear && !ovf_pulse) |=> !flag_q);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ctrl_clear) |=> flag_q);

    // R7
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_COUNT)) |=> (cnt_q == $past(init_q)));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q == mod_q) |=> (cnt_q == $past(init_q)));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q != mod_q) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == 2'd0 || src == 2'd3) && !load) |=> $stable(cnt_q));

    // R9
    irq_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && reg_addr == ADDR_W'(OFS_CTRL)) |-> (reg_rdata[CTRL_FLAG_BIT] && reg_rdata[CTRL_IE_BIT]));

endmodule

bind tick_modulo_timer tmr_checker #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_tmr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .flag_q   (flag_q),
    .ovf_pulse(ovf_pulse),
    .tick     (presc_tick),
    .load     (cnt_load),
    .src      (src_sel),
    .cnt_q    (cnt_q),
    .mod_q    (mod_q),
    .init_q   (init_q)
);

// File: tb/tick_modulo_timer_bench.sv
module tick_modulo_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        fixed_tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [2:0]  m_ps;
    logic [1:0]  m_src;
    logic        m_ie, m_flag, m_run;
    logic [15:0] m_cnt, m_mod, m_init;
    logic [7:0]  m_div;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_modulo_timer u_tick_modulo_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fixed_tick(fixed_tick),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return {24'h0, m_flag, m_ie, 1'b0, m_src, m_ps};
            8'h04:   return {16'h0, m_cnt};
            8'h08:   return {16'h0, m_mod};
            8'h4C:   return {16'h0, m_init};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic model_tick(input logic ft);
        logic ok, en;
        logic [7:0] lim;
        ok  = (m_src == 2'd1) || (m_src == 2'd2);
        en  = (m_src == 2'd1) ? 1'b1 : ((m_src == 2'd2) ? ft : 1'b0);
        lim = (8'd1 << m_ps) - 8'd1;
        return m_run && ok && en && (m_div >= lim);
    endfunction

    function automatic logic model_wrap_due(input logic ft);
        return model_tick(ft) && (m_cnt == m_mod);
    endfunction

    task automatic model_reset();
        m_ps = 3'd0; m_src = 2'd0; m_ie = 1'b0; m_flag = 1'b0; m_run = 1'b0;
        m_cnt = 16'h0; m_mod = 16'hFFFF; m_init = 16'h0; m_div = 8'h0;
    endtask

    // one clock: drive, check combinational outputs, advance model
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                       input logic ft, input string tag);
        logic ok, en, tk, ld, wrap;
        logic [15:0] n_cnt;
        logic [7:0]  n_div;
        logic        n_flag;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; fixed_tick = ft;
        #1;
        check({tag, " read"}, reg_rdata, model_read(a));
        check("R9 irq", {31'h0, irq}, {31'h0, m_flag & m_ie});
        ok   = (m_src == 2'd1) || (m_src == 2'd2);
        en   = (m_src == 2'd1) ? 1'b1 : ((m_src == 2'd2) ? ft : 1'b0);
        tk   = model_tick(ft);
        ld   = wr && (a == 8'h04);
        wrap = tk && (m_cnt == m_mod) && !ld;
        n_cnt  = ld ? m_init : (tk ? ((m_cnt == m_mod) ? m_init : m_cnt + 16'd1) : m_cnt);
        n_div  = (!ok || !m_run) ? 8'h0 : (en ? (tk ? 8'h0 : m_div + 8'd1) : m_div);
        n_flag = wrap ? 1'b1 : ((wr && a == 8'h00 && !wd[7]) ? 1'b0 : m_flag);
        @(posedge clk);
        m_cnt = n_cnt; m_div = n_div; m_flag = n_flag; m_run = ok;
        if (wr && a == 8'h00) begin
            m_ps = wd[2:0]; m_src = wd[4:3]; m_ie = wd[6];
        end
        if (wr && a == 8'h08) m_mod = wd[15:0];
        if (wr && a == 8'h4C) m_init = wd[15:0];
    endtask

    task automatic idle(input int n, input logic [7:0] a, input logic ft, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0, ft, tag);
    endtask

    function automatic logic [31:0] ctrl_word(input logic keep, input logic ie,
                                              input logic [1:0] src, input logic [2:0] ps);
        return {24'h0, keep, ie, 1'b0, src, ps};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, R2: unmapped offset reads zero
        check("R1 ctrl", reg_rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 8'h04, 32'h0, 1'b0, "R1 count");
        cyc(1'b0, 8'h08, 32'h0, 1'b0, "R1 modulus");
        cyc(1'b0, 8'h4C, 32'h0, 1'b0, "R1 start");
        cyc(1'b0, 8'h10, 32'h0, 1'b0, "R2 unmapped");
        // R2: upper bits dropped, spare control bit reads zero
        cyc(1'b1, 8'h08, 32'hABCD_0005, 1'b0, "R2 mod write");
        cyc(1'b1, 8'h4C, 32'h1234_0000, 1'b0, "R2 start write");
        cyc(1'b1, 8'h00, 32'hFFFF_FF20 | ctrl_word(1'b1, 1'b1, 2'd0, 3'd0), 1'b0, "R2 ctrl spare");
        cyc(1'b0, 8'h08, 32'h0, 1'b0, "R2 mod");
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R2 ctrl");
        // R3: stopped source does not count
        idle(5, 8'h04, 1'b1, "R3 stopped");
        // R5 R6 R9: every-clock source, modulus 5, start 0
        cyc(1'b1, 8'h00, ctrl_word(1'b1, 1'b1, 2'd1, 3'd0), 1'b0, "R5 start");
        idle(14, 8'h04, 1'b0, "R5 count");
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R6 flag");
        check("R6 flag set after wrap", {31'h0, m_flag}, 32'h1);
        // R8: write 1 keeps, write 0 clears
        cyc(1'b1, 8'h00, ctrl_word(1'b1, 1'b1, 2'd1, 3'd0), 1'b0, "R8 keep");
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R8 kept");
        // R8: set wins when clear collides with a wrap
        for (int i = 0; i < 40; i++) begin
            if (model_wrap_due(1'b0)) begin
                cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b1, 2'd1, 3'd0), 1'b0, "R8 collide");
                break;
            end
            cyc(1'b0, 8'h04, 32'h0, 1'b0, "R8 wait");
        end
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R8 set wins");
        check("R8 flag survives collision", {31'h0, irq}, 32'h1);
        cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b1, 2'd1, 3'd0), 1'b0, "R8 clear");
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R8 cleared");
        // R7: counter write colliding with a due wrap gives no flag
        for (int i = 0; i < 40; i++) begin
            if (model_wrap_due(1'b0)) begin
                cyc(1'b1, 8'h04, 32'hDEAD_BEEF, 1'b0, "R7 collide");
                break;
            end
            cyc(1'b0, 8'h04, 32'h0, 1'b0, "R7 wait");
        end
        cyc(1'b0, 8'h00, 32'h0, 1'b0, "R7 no flag");
        check("R7 no flag on loaded wrap", {31'h0, irq}, 32'h0);
        // R11: new start value and modulus apply at once
        cyc(1'b1, 8'h4C, 32'h0000_0010, 1'b0, "R11 start");
        cyc(1'b1, 8'h08, 32'h0000_0013, 1'b0, "R11 mod");
        cyc(1'b1, 8'h04, 32'h0, 1'b0, "R7 reload");
        idle(12, 8'h04, 1'b0, "R11 count");
        // R4: prescale 8
        cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b0, 2'd1, 3'd3), 1'b0, "R4 ps3");
        idle(40, 8'h04, 1'b0, "R4 count");
        // R10: stop mid-period then restart
        cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b0, 2'd0, 3'd3), 1'b0, "R10 stop");
        idle(3, 8'h04, 1'b0, "R10 halted");
        cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b0, 2'd1, 3'd3), 1'b0, "R10 restart");
        idle(20, 8'h04, 1'b0, "R10 count");
        // R3: reserved select stops, fixed tick source
        cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b0, 2'd3, 3'd0), 1'b0, "R3 reserved");
        idle(6, 8'h04, 1'b1, "R3 reserved hold");
        cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b1, 2'd2, 3'd1), 1'b0, "R3 fixed");
        for (int i = 0; i < 60; i++) cyc(1'b0, 8'h04, 32'h0, (i % 3) == 0, "R3 fixed count");
        // R4 max prescale
        cyc(1'b1, 8'h08, 32'h0000_0001, 1'b0, "R4 mod");
        cyc(1'b1, 8'h00, ctrl_word(1'b0, 1'b1, 2'd1, 3'd7), 1'b0, "R4 ps7");
        idle(300, 8'h04, 1'b0, "R4 ps7 count");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] wd;
            logic        wr;
            case ($urandom_range(0, 4))
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h08;
                3: a = 8'h4C;
                default: a = 8'h20;
            endcase
            wr = ($urandom_range(0, 9) == 0);
            wd = $urandom;
            if (a == 8'h00) wd[2:0] = 3'($urandom_range(0, 2));
            if (a == 8'h08 || a == 8'h4C) wd[15:0] = 16'($urandom_range(0, 12));
            cyc(wr, a, wd, 1'($urandom_range(0, 1)), "R5 random");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule